// File: doc/BRIEF.md
# Two-Level Opcode Instruction Decoder

This block turns one 32-bit fixed-length instruction word into the control signals a simple in-order datapath needs. The word has a 4-bit major opcode in its top bits, then three 4-bit register fields and a 16-bit immediate. Instructions share one major opcode per family, and a 4-bit function code picks the exact operation. Where that function code lives depends on the family. Register-register families keep it in the low bits of the immediate. Families that read two sources keep it in the destination slot. Families with one source and a destination keep it in the second-source slot.

The decoder is purely combinational. It reports:
- the register read and write indices and the write enable;
- whether operand B comes from a register or from the sign-extended immediate;
- whether the operation is arithmetic/logic or a comparison, and its function code;
- the memory read and write strobes;
- the branch and jump flags;
- the next-PC selection.

Next to the control path it forms the sequential PC, the PC-relative branch target, the register-relative jump target and the load/store address. For the last two it takes the current PC and the value already read from the first source register. Any encoding outside the defined set raises an illegal flag and blocks every side effect.

Top module: `tld_decoder`

## Requirements
- R1: `rs_idx` always equals word bits 23:20 and `rt_idx` always equals bits 19:16. For families that write a register, `rd_idx` is bits 27:24 and `func_code` is taken from the slot that R2 to R9 name.
- R2: Major 0000 (register ALU) writes rd with B from a register and comparison mode off. Its function code is imm[3:0] and imm[15:4] must be zero. Legal codes are ADD 0000, SUB 0001, AND 0100, OR 0101, XOR 0110, NAND 1100, NOR 1101 and NXOR 1110.
- R3: Major 0010 (register compare) writes rd with B from a register and comparison mode on. Its function code is imm[3:0] and imm[15:4] must be zero. The codes 0100 and 1100 are illegal and all other codes are legal.
- R4: Major 1000 (immediate ALU) takes its function code from the rt slot, writes rd and selects the immediate for B. It accepts the R2 codes plus 1011, which loads the upper half.
- R5: Major 1010 (immediate compare) takes its function code from the rt slot, writes rd, selects the immediate for B and turns comparison mode on. It accepts the compare codes of R3.
- R6: Major 1001 (load) is legal only with rt-slot code 0000. It raises `mem_rd`, writes rd, selects the immediate for B, and `mem_addr` = rs_val + sext(imm).
- R7: Major 0101 (store) is legal only with rd-slot code 0000. It raises `mem_wr`, writes no register, selects the immediate for B, and `mem_addr` = rs_val + sext(imm).
- R8: Major 0110 (conditional branch) takes a compare code from the rd slot and accepts the codes of R3. It raises `is_branch` with comparison mode on, writes nothing, sets `next_pc_sel` to 01, and `branch_target` = pc + 4 + sext(imm)*4.
- R9: Major 1011 (jump and link) is legal only with rt-slot code 0000. It writes rd and raises `is_jump`, sets `next_pc_sel` to 10, and `link_value` = pc + 4. `jump_target` = rs_val + 4*sext(imm) comes from the `rs_val` input even when rd equals rs.
- R10: Any other major opcode, or any function code outside R2 to R9, raises `illegal`. It also clears `reg_we`, `mem_rd`, `mem_wr`, `is_branch`, `is_jump`, `b_from_imm` and `cmp_mode`, and sets `next_pc_sel` to 00.
- R11: `imm_ext` is imm sign-extended to 32 bits, and every address and target wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction being decoded |
| pc | input | 32 | Byte address of that instruction |
| rs_val | input | 32 | Value read from register rs |
| rs_idx | output | 4 | First source register index |
| rt_idx | output | 4 | Second source register index |
| rd_idx | output | 4 | Destination register index |
| reg_we | output | 1 | Register write enable |
| b_from_imm | output | 1 | Operand B is the sign-extended immediate |
| imm_ext | output | 32 | Sign-extended immediate |
| cmp_mode | output | 1 | Function code is a comparison |
| func_code | output | 4 | Selected secondary opcode |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| is_branch | output | 1 | Conditional branch |
| is_jump | output | 1 | Jump and link |
| next_pc_sel | output | 2 | 00 sequential, 01 branch, 10 jump |
| illegal | output | 1 | Encoding is not defined |
| link_value | output | 32 | pc + 4 |
| branch_target | output | 32 | PC-relative branch destination |
| jump_target | output | 32 | Register-relative jump destination |
| mem_addr | output | 32 | Load/store effective address |

## Verification
Each family is given both a legal encoding and a near miss: the correct major opcode with a function code that is defined for some other family. This separates the function code being read from the right slot from it being read from a neighbouring one. Register-form words with a stray bit in imm[15:4] show that the padding rule is enforced. Unused major opcodes show that every side effect is cleared. Immediates of zero, plus one, minus one and the most negative value, together with a PC near the top of the address space, separate a correct sign extension, the times-four scaling and the modulo wrap from a truncated or unscaled result. A jump whose rd equals its rs shows that the target is formed from `rs_val` and not from the link value.

// File: rtl/tld_pkg.sv
package tld_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 16;
    localparam int FUNC_W = 4;

    typedef enum logic [3:0] {
        MAJ_ALUR  = 4'b0000,
        MAJ_CMPR  = 4'b0010,
        MAJ_STORE = 4'b0101,
        MAJ_BCOND = 4'b0110,
        MAJ_ALUI  = 4'b1000,
        MAJ_LOAD  = 4'b1001,
        MAJ_CMPI  = 4'b1010,
        MAJ_JAL   = 4'b1011
    } major_e;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'b00,
        NXT_BRANCH = 2'b01,
        NXT_JUMP   = 2'b10
    } next_pc_e;

    typedef enum logic [1:0] {
        SLOT_IMM  = 2'd0,
        SLOT_RD   = 2'd1,
        SLOT_RT   = 2'd2,
        SLOT_NONE = 2'd3
    } func_slot_e;

    typedef struct packed {
        logic [3:0]       major;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [IMM_W-1:0] imm;
    } word_t;

    typedef struct packed {
        logic              illegal;
        logic              reg_we;
        logic [REG_W-1:0]  wr_idx;
        logic              b_imm;
        logic              cmp_mode;
        logic [FUNC_W-1:0] func;
        logic              mem_rd;
        logic              mem_wr;
        logic              is_branch;
        logic              is_jump;
        next_pc_e          next_sel;
    } ctrl_t;

    // Which field carries the function code for a given family
    function automatic func_slot_e slot_of(input logic [3:0] major);
        case (major)
            MAJ_ALUR, MAJ_CMPR:                       return SLOT_IMM;
            MAJ_STORE, MAJ_BCOND:                     return SLOT_RD;
            MAJ_ALUI, MAJ_LOAD, MAJ_CMPI, MAJ_JAL:    return SLOT_RT;
            default:                                  return SLOT_NONE;
        endcase
    endfunction

    // Arithmetic/logic codes; the upper-half load exists only in immediate form
    function automatic logic alu_code_ok(input logic [FUNC_W-1:0] f, input logic imm_form);
        case (f)
            4'b0000, 4'b0001,
            4'b0100, 4'b0101, 4'b0110,
            4'b1100, 4'b1101, 4'b1110: return 1'b1;
            4'b1011:                   return imm_form;
            default:                   return 1'b0;
        endcase
    endfunction

    // Comparison codes: only x100 is left undefined
    function automatic logic cmp_code_ok(input logic [FUNC_W-1:0] f);
        return f[2:0] != 3'b100;
    endfunction

endpackage

// File: rtl/tld_fields.sv
module tld_fields
    import tld_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output word_t             fld,
    output logic [FUNC_W-1:0] func,
    output logic              pad_clear
);
    localparam int PAD_W = IMM_W - FUNC_W;

    assign fld = word_t'(instr);

    always_comb begin
        case (slot_of(fld.major))
            SLOT_IMM: func = fld.imm[FUNC_W-1:0];
            SLOT_RD:  func = fld.rd;
            SLOT_RT:  func = fld.rt;
            default:  func = '0;
        endcase
    end

    assign pad_clear = (fld.imm[IMM_W-1:FUNC_W] == {PAD_W{1'b0}});

endmodule

// File: rtl/tld_ctrl.sv
module tld_ctrl
    import tld_pkg::*;
(
    input  logic [3:0]        major,
    input  logic [REG_W-1:0]  rd,
    input  logic [FUNC_W-1:0] func,
    input  logic              pad_clear,
    output ctrl_t             ctl
);
    logic legal;

    always_comb begin
        ctl          = '0;
        ctl.next_sel = NXT_SEQ;
        ctl.func     = func;
        ctl.wr_idx   = rd;
        legal        = 1'b0;
        case (major)
            MAJ_ALUR: begin
                legal      = pad_clear && alu_code_ok(func, 1'b0);
                ctl.reg_we = 1'b1;
            end
            MAJ_CMPR: begin
                legal        = pad_clear && cmp_code_ok(func);
                ctl.reg_we   = 1'b1;
                ctl.cmp_mode = 1'b1;
            end
            MAJ_ALUI: begin
                legal      = alu_code_ok(func, 1'b1);
                ctl.reg_we = 1'b1;
                ctl.b_imm  = 1'b1;
            end
            MAJ_CMPI: begin
                legal        = cmp_code_ok(func);
                ctl.reg_we   = 1'b1;
                ctl.b_imm    = 1'b1;
                ctl.cmp_mode = 1'b1;
            end
            MAJ_LOAD: begin
                legal      = (func == '0);
                ctl.reg_we = 1'b1;
                ctl.mem_rd = 1'b1;
                ctl.b_imm  = 1'b1;
            end
            MAJ_STORE: begin
                legal      = (func == '0);
                ctl.mem_wr = 1'b1;
                ctl.b_imm  = 1'b1;
            end
            MAJ_BCOND: begin
                legal         = cmp_code_ok(func);
                ctl.cmp_mode  = 1'b1;
                ctl.is_branch = 1'b1;
                ctl.next_sel  = NXT_BRANCH;
            end
            MAJ_JAL: begin
                legal        = (func == '0);
                ctl.reg_we   = 1'b1;
                ctl.b_imm    = 1'b1;
                ctl.is_jump  = 1'b1;
                ctl.next_sel = NXT_JUMP;
            end
            default: legal = 1'b0;
        endcase

        if (!legal) begin
            ctl.illegal   = 1'b1;
            ctl.reg_we    = 1'b0;
            ctl.mem_rd    = 1'b0;
            ctl.mem_wr    = 1'b0;
            ctl.b_imm     = 1'b0;
            ctl.cmp_mode  = 1'b0;
            ctl.is_branch = 1'b0;
            ctl.is_jump   = 1'b0;
            ctl.next_sel  = NXT_SEQ;
        end
    end

endmodule

// File: rtl/tld_targets.sv
module tld_targets #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  imm_sx,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_target,
    output logic [XLEN-1:0]  jmp_target,
    output logic [XLEN-1:0]  ea
);
    localparam int EXT_W    = XLEN - IMM_W;
    localparam int WORD_LG2 = 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(1 << WORD_LG2);

    logic [XLEN-1:0] imm_words;

    assign imm_sx     = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_words  = {imm_sx[XLEN-WORD_LG2-1:0], {WORD_LG2{1'b0}}};
    assign seq_pc     = pc + STEP;
    assign br_target  = seq_pc + imm_words;
    assign jmp_target = rs_val + imm_words;
    assign ea         = rs_val + imm_sx;

endmodule

// File: rtl/tld_decoder.sv
module tld_decoder
    import tld_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [WORD_W-1:0] instr_word,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs_val,
    output logic [REG_W-1:0]  rs_idx,
    output logic [REG_W-1:0]  rt_idx,
    output logic [REG_W-1:0]  rd_idx,
    output logic              reg_we,
    output logic              b_from_imm,
    output logic [XLEN-1:0]   imm_ext,
    output logic              cmp_mode,
    output logic [FUNC_W-1:0] func_code,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              is_branch,
    output logic              is_jump,
    output logic [1:0]        next_pc_sel,
    output logic              illegal,
    output logic [XLEN-1:0]   link_value,
    output logic [XLEN-1:0]   branch_target,
    output logic [XLEN-1:0]   jump_target,
    output logic [XLEN-1:0]   mem_addr
);
    word_t             fld;
    logic [FUNC_W-1:0] func;
    logic              pad_clear;
    ctrl_t             ctl;

    tld_fields u_fields (
        .instr     (instr_word),
        .fld       (fld),
        .func      (func),
        .pad_clear (pad_clear)
    );

    tld_ctrl u_ctrl (
        .major     (fld.major),
        .rd        (fld.rd),
        .func      (func),
        .pad_clear (pad_clear),
        .ctl       (ctl)
    );

    tld_targets #(.XLEN(XLEN), .IMM_W(IMM_W)) u_targets (
        .pc         (pc),
        .rs_val     (rs_val),
        .imm        (fld.imm),
        .imm_sx     (imm_ext),
        .seq_pc     (link_value),
        .br_target  (branch_target),
        .jmp_target (jump_target),
        .ea         (mem_addr)
    );

    assign rs_idx      = fld.rs;
    assign rt_idx      = fld.rt;
    assign rd_idx      = ctl.wr_idx;
    assign reg_we      = ctl.reg_we;
    assign b_from_imm  = ctl.b_imm;
    assign cmp_mode    = ctl.cmp_mode;
    assign func_code   = ctl.func;
    assign mem_rd      = ctl.mem_rd;
    assign mem_wr      = ctl.mem_wr;
    assign is_branch   = ctl.is_branch;
    assign is_jump     = ctl.is_jump;
    assign next_pc_sel = ctl.next_sel;
    assign illegal     = ctl.illegal;

    always_comb begin
        if (!$isunknown({instr_word, pc})) begin
            a_r10_no_effect_when_illegal: assert (!(illegal && (reg_we || mem_rd || mem_wr || is_branch || is_jump)))
                else $error("illegal word still has a side effect");
            a_r6_one_effect: assert ($onehot0({mem_rd, mem_wr, is_branch, is_jump}))
                else $error("more than one memory or flow effect");
            a_r7_store_no_regwrite: assert (!(mem_wr && reg_we))
                else $error("store also writes a register");
            a_r8_branch_selects_branch: assert (!is_branch || next_pc_sel == NXT_BRANCH)
                else $error("branch flag without branch selection");
            a_r2_pad_rule: assert (!((fld.major == MAJ_ALUR || fld.major == MAJ_CMPR) && !pad_clear) || illegal)
                else $error("nonzero padding accepted");
            a_r8_target_alignment: assert (branch_target[1:0] == pc[1:0])
                else $error("branch target changes word offset");
        end
    end

endmodule

// File: tb/tld_decoder_test.sv
module tld_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr_word, pc, rs_val;
    logic [3:0]  rs_idx, rt_idx, rd_idx, func_code;
    logic        reg_we, b_from_imm, cmp_mode, mem_rd, mem_wr, is_branch, is_jump, illegal;
    logic [1:0]  next_pc_sel;
    logic [31:0] imm_ext, link_value, branch_target, jump_target, mem_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tld_decoder uut (
        .instr_word, .pc, .rs_val, .rs_idx, .rt_idx, .rd_idx, .reg_we, .b_from_imm,
        .imm_ext, .cmp_mode, .func_code, .mem_rd, .mem_wr, .is_branch, .is_jump,
        .next_pc_sel, .illegal, .link_value, .branch_target, .jump_target, .mem_addr
    );

    // {instr[31:0], illegal, we, rd[3:0], bimm, cmp, func[3:0], mrd, mwr, br, jmp, nxt[1:0]}
    localparam int NV = 22;
    localparam logic [49:0] VEC [NV] = '{
        {32'h0312_0000, 18'b0_1_0011_0_0_0000_0_0_0_0_00}, // R2 ADD
        {32'h0567_000E, 18'b0_1_0101_0_0_1110_0_0_0_0_00}, // R2 NXOR
        {32'h0567_0011, 18'b1_0_0101_0_0_0001_0_0_0_0_00}, // R2 padding bit set
        {32'h0112_0002, 18'b1_0_0001_0_0_0010_0_0_0_0_00}, // R10 undefined ALU code
        {32'h2489_0002, 18'b0_1_0100_0_1_0010_0_0_0_0_00}, // R3 LT
        {32'h2489_0004, 18'b1_0_0100_0_0_0100_0_0_0_0_00}, // R3 hole 0100
        {32'h8230_FFFC, 18'b0_1_0010_1_0_0000_0_0_0_0_00}, // R4 ADDI
        {32'h870B_1234, 18'b0_1_0111_1_0_1011_0_0_0_0_00}, // R4 upper-half load
        {32'h0700_000B, 18'b1_0_0111_0_0_1011_0_0_0_0_00}, // R2 upper-half code not in register form
        {32'hA12A_0005, 18'b0_1_0001_1_1_1010_0_0_0_0_00}, // R5 GTE
        {32'h9640_0008, 18'b0_1_0110_1_0_0000_1_0_0_0_00}, // R6 load
        {32'h9641_0008, 18'b1_0_0110_0_0_0001_0_0_0_0_00}, // R6 half-word load undefined
        {32'h5045_000C, 18'b0_0_0000_1_0_0000_0_1_0_0_00}, // R7 store
        {32'h5245_000C, 18'b1_0_0010_0_0_0010_0_0_0_0_00}, // R7 store code 0010
        {32'h6112_FFFF, 18'b0_0_0001_0_1_0001_0_0_1_0_01}, // R8 EQ
        {32'h6800_0003, 18'b0_0_1000_0_1_1000_0_0_1_0_01}, // R8 always
        {32'h6C00_0003, 18'b1_0_1100_0_0_1100_0_0_0_0_00}, // R8 hole 1100
        {32'hBF40_0002, 18'b0_1_1111_1_0_0000_0_0_0_1_10}, // R9 jump and link
        {32'hBF41_0002, 18'b1_0_1111_0_0_0001_0_0_0_0_00}, // R9 code 0001
        {32'h1123_0000, 18'b1_0_0001_0_0_0000_0_0_0_0_00}, // R10 unused major 0001
        {32'hF000_0000, 18'b1_0_0000_0_0_0000_0_0_0_0_00}, // R10 unused major 1111
        {32'hA335_0000, 18'b0_1_0011_1_1_0101_0_0_0_0_00}  // R5 EQZ
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] p, input logic [31:0] r);
        @(posedge clk);
        #1;
        instr_word = w;
        pc         = p;
        rs_val     = r;
        @(negedge clk);
    endtask

    function automatic logic [31:0] sx(input logic [15:0] i);
        return {{16{i[15]}}, i};
    endfunction

    function automatic logic [17:0] ctl_now();
        return {illegal, reg_we, rd_idx, b_from_imm, cmp_mode, func_code,
                mem_rd, mem_wr, is_branch, is_jump, next_pc_sel};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        instr_word = '0;
        pc         = '0;
        rs_val     = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero word decodes as legal ADD r0 (R2)
        check("R2", "reset-state control", {14'd0, ctl_now()}, {14'd0, 18'b0_1_0000_0_0_0000_0_0_0_0_00});
        check("R11", "reset-state link", link_value, 32'h4);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            logic [31:0] w;
            logic [31:0] exp_br, exp_jmp, exp_ea;
            w = VEC[k][49:18];
            apply(w, 32'h0000_1000, 32'h0000_2000);
            exp_br  = 32'h0000_1004 + (sx(w[15:0]) << 2);
            exp_jmp = 32'h0000_2000 + (sx(w[15:0]) << 2);
            exp_ea  = 32'h0000_2000 + sx(w[15:0]);
            check("table", $sformatf("control vector %0d", k), {14'd0, ctl_now()}, {14'd0, VEC[k][17:0]});
            check("R1", $sformatf("source indices vector %0d", k), {24'd0, rs_idx, rt_idx}, {24'd0, w[23:20], w[19:16]});
            check("R11", $sformatf("imm_ext vector %0d", k), imm_ext, sx(w[15:0]));
            if (is_branch) check("R8", $sformatf("branch target vector %0d", k), branch_target, exp_br);
            if (is_jump)   check("R9", $sformatf("jump target vector %0d", k), jump_target, exp_jmp);
            if (mem_rd || mem_wr) check("R6", $sformatf("address vector %0d", k), mem_addr, exp_ea);
        end

        // R8 backward by one word lands on itself
        apply(32'h6100_FFFF, 32'h0000_1000, 32'h0);
        check("R8", "branch minus one word", branch_target, 32'h0000_1000);
        check("R8", "branch next select", {30'd0, next_pc_sel}, 32'h1);

        // R9 rd equals rs: target from rs_val, link from pc
        apply(32'hB440_0002, 32'h0000_1000, 32'h0000_2000);
        check("R9", "jump target rd==rs", jump_target, 32'h0000_2008);
        check("R9", "link value", link_value, 32'h0000_1004);
        check("R9", "writes rd", {27'd0, reg_we, rd_idx}, {27'd0, 1'b1, 4'h4});

        // R11 most negative immediate
        apply(32'hB140_8000, 32'h0000_1000, 32'h0000_2000);
        check("R11", "jump most negative", jump_target, 32'hFFFE_2000);
        check("R11", "imm_ext most negative", imm_ext, 32'hFFFF_8000);

        // R6 negative displacement
        apply(32'h9640_FFFC, 32'h0, 32'h0000_2000);
        check("R6", "load address minus four", mem_addr, 32'h0000_1FFC);
        check("R6", "load strobes", {30'd0, mem_rd, mem_wr}, 32'h2);

        // R7 largest positive displacement, no register write
        apply(32'h5045_7FFF, 32'h0, 32'h0000_2000);
        check("R7", "store address", mem_addr, 32'h0000_9FFF);
        check("R7", "store no reg write", {31'd0, reg_we}, 32'h0);

        // R11 wrap at top of address space
        apply(32'h6800_0000, 32'hFFFF_FFFC, 32'h0);
        check("R11", "link wraps", link_value, 32'h0);
        check("R11", "branch wraps", branch_target, 32'h0);

        // R3 padding bit in compare register form
        apply(32'h2489_8001, 32'h0, 32'h0);
        check("R3", "compare padding illegal", {31'd0, illegal}, 32'h1);

        // R10 illegal clears operand select and compare mode
        apply(32'hA124_0000, 32'h0, 32'h0);
        check("R10", "illegal compare-imm clears", {29'd0, b_from_imm, cmp_mode, reg_we}, 32'h0);

        // R4 and R5 operand-B sources
        apply(32'h8124_0010, 32'h0, 32'h0);
        check("R4", "ALUI AND uses immediate", {30'd0, b_from_imm, cmp_mode}, 32'h2);
        apply(32'hA12F_0010, 32'h0, 32'h0);
        check("R5", "CMPI GTZ", {28'd0, func_code}, 32'hF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule